// File: doc/BRIEF.md
# Local Bus Hand-over Controller

This block sits beside a processor's bus interface and lets other masters on the local bus borrow it. Each borrowing master has one shared, active-low, open-drain line. On that line a hand-over always takes three one-clock low pulses. The other master pulses to ask for the bus. The processor pulses to hand it over. The other master pulses again to give it back. The controller watches the processor's bus-cycle phase and latches incoming requests. It drives the hand-over pulse only in a clock where giving up the bus is legal. It floats the bus interface while the bus is lent out and takes the bus back on the clock after the give-back pulse.

Whether the bus can be given up depends on the current memory cycle. The request must have been seen early enough, the cycle must not be the first half of a split odd-address word, it must not be the first interrupt-acknowledge cycle, and no locked instruction may be running. If the bus is idle, it is handed over in the next clock. When several lines request in the same clock, the lowest-numbered line wins. The block also produces the active-low bus-lock output, for locked instructions and for the span between the two interrupt-acknowledge cycles. Each line is modelled as a sampled input plus a pull-down enable, and the lock output has its own enable.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: After reset no line is pulled low, the bus is not floated, reclaim_o and resume_t4_o are 0, and the lock output is driven (lock_oe_o=1) at 1.
- R2: A request is a line sampled low in a clock where the block does not pull that line. The hand-over pulse sets exactly one bit of line_pull_o for exactly one clock. It is never given in the clock in which the request is seen. With phase_i idle (encoding 0) and no locked instruction, it comes in the clock right after the request.
- R3: The hand-over pulse appears only while phase_i is idle (0) or T4 (4). In a memory cycle (T1=1, T2=2, T3=3, T4=4) where the request was seen in T1 or T2, and none of the blocking conditions holds, the pulse comes in that cycle's T4.
- R4: A request first seen in T3 is not served in that cycle's T4. It is served in the T4 of the next memory cycle.
- R5: No hand-over pulse is given in a T4 while split_low_i is 1, or while both inta_i and inta_first_i are 1. None is given in any clock while locked_i is 1.
- R6: bus_float_o is 1 from the clock after the hand-over pulse up to and including the clock in which the owning line is sampled low again. In the clock after that, bus_float_o is 0, reclaim_o is 1 for that single clock, and resume_t4_o equals pending_i.
- R7: While bus_float_o is 1, lock_oe_o is 0 and lock_n_o is 1.
- R8: When both lines have pending requests, line 0 is handed the bus first. Line 1 is served after line 0 gives it back.
- R9: A request seen on another line while the bus is lent out is kept. It is not served in the reclaim clock. It is served in the following clock if phase_i is idle then.
- R10: lock_n_o is 0 whenever locked_i is 1 and the bus is not floated.
- R11: lock_n_o goes to 0 in the T2 of an interrupt-acknowledge cycle with inta_first_i=1. It stays 0 until the T2 of the next interrupt-acknowledge cycle with inta_first_i=0, where it is already 1.
- R12: A request seen in an idle clock that is followed by T1 is served in the T4 of that memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Bus-cycle phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, other values act as wait |
| split_low_i | input | 1 | Current cycle is the low byte of a word at an odd address |
| inta_i | input | 1 | Current cycle is an interrupt acknowledge |
| inta_first_i | input | 1 | The acknowledge cycle is the first of its pair |
| locked_i | input | 1 | A lock-prefixed instruction is executing |
| pending_i | input | 1 | A bus cycle waits to run when the bus is taken back |
| line_n_i | input | NUM_CH | Sampled level of each hand-over line (pulled up, active low) |
| line_pull_o | output | NUM_CH | Pull-low enable for each hand-over line |
| bus_float_o | output | 1 | Bus interface released to the other master |
| reclaim_o | output | 1 | One-clock strobe in the clock the bus is taken back |
| resume_t4_o | output | 1 | With reclaim_o: the core resumes in T4 rather than idle |
| lock_n_o | output | 1 | Active-low bus-lock value |
| lock_oe_o | output | 1 | Drive enable for the lock output |

## Verification
The hand-over pulse is decided from registered request state and the live phase. It therefore appears in the clock after the request in idle, or in the T4 clock of a qualifying cycle. Float starts one clock after the pulse and ends one clock after the give-back pulse. The lock output follows its inputs in the same clock. Inputs change just after a rising edge and every output is checked on the falling edge of the clock in which the requirement says it is due. A request, a phase step and a give-back each cost exactly one clock in the directed tasks.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    localparam logic [2:0] PH_IDLE = 3'd0;
    localparam logic [2:0] PH_T1   = 3'd1;
    localparam logic [2:0] PH_T2   = 3'd2;
    localparam logic [2:0] PH_T3   = 3'd3;
    localparam logic [2:0] PH_T4   = 3'd4;

    typedef enum logic [1:0] {
        HS_OWN,
        HS_FLOAT,
        HS_GAP
    } hs_state_e;

    typedef struct packed {
        logic split_low;
        logic inta_first;
        logic locked;
    } cyc_attr_t;

    // clocks in which a request still counts as early for the current cycle
    function automatic logic is_early_phase(input logic [2:0] ph);
        return (ph == PH_IDLE) || (ph == PH_T1) || (ph == PH_T2);
    endfunction

endpackage

// File: rtl/bhc_line_sampler.sv
module bhc_line_sampler (
    input  logic line_n_i,
    input  logic pull_i,
    output logic seen_o
);
    // a low level only counts when this block is not the one pulling it
    assign seen_o = ~pull_i & ~line_n_i;
endmodule

// File: rtl/bhc_grant_fsm.sv
module bhc_grant_fsm
    import bhc_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        phase_i,
    input  cyc_attr_t         attr_i,
    input  logic              pending_i,
    input  logic [NUM_CH-1:0] seen_i,
    output logic [NUM_CH-1:0] pull_o,
    output logic              float_o,
    output logic              reclaim_o,
    output logic              resume_t4_o
);
    hs_state_e         state_q, state_d;
    logic [CH_W-1:0]   owner_q, sel;
    logic [NUM_CH-1:0] req_q, req_d, new_req, owner_mask, grant_vec;
    logic              early_q, early_d, found, grant_ok, give_back;

    // lowest-numbered pending line wins
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req_q[c] && !found) begin
                sel   = CH_W'(c);
                found = 1'b1;
            end
        end
    end

    assign owner_mask = (state_q == HS_FLOAT) ? (NUM_CH'(1) << owner_q) : '0;
    assign new_req    = seen_i & ~owner_mask;
    assign give_back  = (state_q == HS_FLOAT) && seen_i[owner_q];

    always_comb begin
        grant_ok = 1'b0;
        if (state_q == HS_OWN && found && !attr_i.locked) begin
            if (phase_i == PH_IDLE)
                grant_ok = 1'b1;
            else if (phase_i == PH_T4 && early_q && !attr_i.split_low && !attr_i.inta_first)
                grant_ok = 1'b1;
        end
    end

    assign grant_vec = grant_ok ? (NUM_CH'(1) << sel) : '0;
    assign req_d     = (req_q | new_req) & ~grant_vec;

    always_comb begin
        if (state_q != HS_OWN || grant_ok || phase_i == PH_T4)
            early_d = 1'b0;
        else if (is_early_phase(phase_i) && ((req_q | new_req) != '0))
            early_d = 1'b1;
        else
            early_d = early_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_OWN:   if (grant_ok)  state_d = HS_FLOAT;
            HS_FLOAT: if (give_back) state_d = HS_GAP;
            HS_GAP:   state_d = HS_OWN;
            default:  state_d = HS_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_OWN;
            owner_q <= '0;
            req_q   <= '0;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
            early_q <= early_d;
            if (grant_ok) owner_q <= sel;
        end
    end

    assign pull_o      = grant_vec;
    assign float_o     = (state_q == HS_FLOAT);
    assign reclaim_o   = (state_q == HS_GAP);
    assign resume_t4_o = (state_q == HS_GAP) && pending_i;
endmodule

// File: rtl/bhc_lock_gen.sv
module bhc_lock_gen
    import bhc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] phase_i,
    input  logic       inta_i,
    input  logic       inta_first_i,
    input  logic       locked_i,
    input  logic       float_i,
    output logic       lock_n_o,
    output logic       lock_oe_o
);
    logic win_q, open_now, close_now, lock_act;

    assign open_now  = (phase_i == PH_T2) && inta_i && inta_first_i;
    assign close_now = (phase_i == PH_T2) && inta_i && !inta_first_i;

    always_ff @(posedge clk) begin
        if (rst)            win_q <= 1'b0;
        else if (open_now)  win_q <= 1'b1;
        else if (close_now) win_q <= 1'b0;
    end

    assign lock_act  = locked_i | open_now | (win_q & ~close_now);
    // released output: enable off, weak level reads as one
    assign lock_n_o  = float_i | ~lock_act;
    assign lock_oe_o = ~float_i;
endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
    import bhc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        phase_i,
    input  logic              split_low_i,
    input  logic              inta_i,
    input  logic              inta_first_i,
    input  logic              locked_i,
    input  logic              pending_i,
    input  logic [NUM_CH-1:0] line_n_i,
    output logic [NUM_CH-1:0] line_pull_o,
    output logic              bus_float_o,
    output logic              reclaim_o,
    output logic              resume_t4_o,
    output logic              lock_n_o,
    output logic              lock_oe_o
);
    logic [NUM_CH-1:0] seen;
    cyc_attr_t         attr;

    assign attr.split_low  = split_low_i;
    assign attr.inta_first = inta_i & inta_first_i;
    assign attr.locked     = locked_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        bhc_line_sampler u_smp (
            .line_n_i (line_n_i[c]),
            .pull_i   (line_pull_o[c]),
            .seen_o   (seen[c])
        );
    end

    bhc_grant_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase_i),
        .attr_i      (attr),
        .pending_i   (pending_i),
        .seen_i      (seen),
        .pull_o      (line_pull_o),
        .float_o     (bus_float_o),
        .reclaim_o   (reclaim_o),
        .resume_t4_o (resume_t4_o)
    );

    bhc_lock_gen u_lock (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase_i),
        .inta_i       (inta_i),
        .inta_first_i (inta_first_i),
        .locked_i     (locked_i),
        .float_i      (bus_float_o),
        .lock_n_o     (lock_n_o),
        .lock_oe_o    (lock_oe_o)
    );
endmodule

// File: rtl/bus_handoff_ctrl_chk.sv
module bus_handoff_ctrl_chk
    import bhc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        phase_i,
    input logic              locked_i,
    input logic [NUM_CH-1:0] line_pull_o,
    input logic              bus_float_o,
    input logic              reclaim_o,
    input logic              lock_n_o,
    input logic              lock_oe_o
);
    assert_pull_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_pull_o));

    assert_pull_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
        (line_pull_o != '0) |=> (line_pull_o == '0));

    assert_pull_phase_R3: assert property (@(posedge clk) disable iff (rst)
        (line_pull_o != '0) |-> (phase_i == PH_IDLE || phase_i == PH_T4));

    assert_float_after_pull_R6: assert property (@(posedge clk) disable iff (rst)
        (line_pull_o != '0) |=> bus_float_o);

    assert_reclaim_single_R6: assert property (@(posedge clk) disable iff (rst)
        reclaim_o |=> !reclaim_o);

    assert_float_end_reclaim_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_float_o) |-> reclaim_o);

    assert_lock_released_R7: assert property (@(posedge clk) disable iff (rst)
        bus_float_o |-> (!lock_oe_o && lock_n_o));

    assert_no_pull_reclaim_R9: assert property (@(posedge clk) disable iff (rst)
        reclaim_o |-> (line_pull_o == '0));

    assert_lock_insn_R10: assert property (@(posedge clk) disable iff (rst)
        (locked_i && !bus_float_o) |-> !lock_n_o);
endmodule

bind bus_handoff_ctrl bus_handoff_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase_i),
    .locked_i    (locked_i),
    .line_pull_o (line_pull_o),
    .bus_float_o (bus_float_o),
    .reclaim_o   (reclaim_o),
    .lock_n_o    (lock_n_o),
    .lock_oe_o   (lock_oe_o)
);

// File: tb/bus_handoff_ctrl_tb.sv
module bus_handoff_ctrl_tb;
    import bhc_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] phase;
    logic       split_low, inta, inta_first, locked, pending;
    logic [1:0] line_n;
    logic [1:0] pull;
    logic       bus_float, reclaim, resume_t4, lock_n, lock_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bus_handoff_ctrl #(.NUM_CH(2)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .phase_i      (phase),
        .split_low_i  (split_low),
        .inta_i       (inta),
        .inta_first_i (inta_first),
        .locked_i     (locked),
        .pending_i    (pending),
        .line_n_i     (line_n),
        .line_pull_o  (pull),
        .bus_float_o  (bus_float),
        .reclaim_o    (reclaim),
        .resume_t4_o  (resume_t4),
        .lock_n_o     (lock_n),
        .lock_oe_o    (lock_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    // owning line pulses low while floated, then the gap clock follows
    task automatic give_back(input int ch, input logic pend);
        phase = PH_IDLE;
        line_n[ch] = 1'b0;
        mid();
        check("R6 float through give-back clock", 32'(bus_float), 1);
        nxt();
        line_n[ch] = 1'b1;
        pending = pend;
        mid();
        check("R6 float ends", 32'(bus_float), 0);
        check("R6 reclaim strobe", 32'(reclaim), 1);
        check("R6 resume in T4", 32'(resume_t4), 32'(pend));
        check("R9 no pull in reclaim clock", 32'(pull), 0);
        check("R7 lock driven again", 32'(lock_oe), 1);
        nxt();
        pending = 1'b0;
    endtask

    task automatic t_reset();
        mid();
        check("R1 pull", 32'(pull), 0);
        check("R1 float", 32'(bus_float), 0);
        check("R1 reclaim", 32'(reclaim), 0);
        check("R1 resume", 32'(resume_t4), 0);
        check("R1 lock value", 32'(lock_n), 1);
        check("R1 lock enable", 32'(lock_oe), 1);
        nxt();
    endtask

    task automatic t_idle_grant();
        phase = PH_IDLE;
        line_n = 2'b10;
        mid();
        check("R2 no pulse in request clock", 32'(pull), 0);
        nxt();
        line_n = 2'b11;
        mid();
        check("R2 pulse on line 0", 32'(pull), 1);
        nxt();
        mid();
        check("R2 pulse one clock", 32'(pull), 0);
        check("R6 floated after pulse", 32'(bus_float), 1);
        check("R7 lock enable off", 32'(lock_oe), 0);
        check("R7 lock reads one", 32'(lock_n), 1);
        nxt();
        give_back(0, 1'b1);
        mid();
        check("R6 reclaim lasts one clock", 32'(reclaim), 0);
        nxt();
    endtask

    task automatic t_mem_t2();
        phase = PH_T1;
        mid();
        nxt();
        phase = PH_T2;
        line_n = 2'b10;
        mid();
        nxt();
        line_n = 2'b11;
        phase = PH_T3;
        mid();
        check("R3 no pulse in T3", 32'(pull), 0);
        nxt();
        phase = PH_T4;
        mid();
        check("R3 pulse in T4", 32'(pull), 1);
        nxt();
        phase = PH_IDLE;
        nxt();
        give_back(0, 1'b0);
    endtask

    task automatic t_late();
        phase = PH_T1;
        nxt();
        phase = PH_T2;
        nxt();
        phase = PH_T3;
        line_n = 2'b10;
        nxt();
        line_n = 2'b11;
        phase = PH_T4;
        mid();
        check("R4 late request skips this T4", 32'(pull), 0);
        nxt();
        phase = PH_T1;
        mid();
        check("R4 no pulse in T1", 32'(pull), 0);
        nxt();
        phase = PH_T2;
        nxt();
        phase = PH_T3;
        nxt();
        phase = PH_T4;
        mid();
        check("R4 served in next T4", 32'(pull), 1);
        nxt();
        phase = PH_IDLE;
        nxt();
        give_back(0, 1'b0);
    endtask

    task automatic t_block(input int which);
        phase = PH_T1;
        line_n = 2'b10;
        nxt();
        line_n = 2'b11;
        phase = PH_T2;
        nxt();
        phase = PH_T3;
        nxt();
        phase = PH_T4;
        if (which == 0) split_low = 1'b1;
        if (which == 1) begin inta = 1'b1; inta_first = 1'b1; end
        if (which == 2) locked = 1'b1;
        mid();
        check($sformatf("R5 blocked in T4 case %0d", which), 32'(pull), 0);
        nxt();
        split_low = 1'b0;
        inta = 1'b0;
        inta_first = 1'b0;
        phase = PH_IDLE;
        if (which == 2) begin
            mid();
            check("R5 locked blocks idle too", 32'(pull), 0);
            nxt();
            locked = 1'b0;
        end
        mid();
        check($sformatf("R5 served once clear case %0d", which), 32'(pull), 1);
        nxt();
        nxt();
        give_back(0, 1'b0);
    endtask

    task automatic t_prio();
        phase = PH_IDLE;
        line_n = 2'b00;
        nxt();
        line_n = 2'b11;
        mid();
        check("R8 line 0 first", 32'(pull), 1);
        nxt();
        nxt();
        give_back(0, 1'b0);
        mid();
        check("R8 line 1 after", 32'(pull), 2);
        nxt();
        nxt();
        give_back(1, 1'b0);
        nxt();
    endtask

    task automatic t_float_req();
        phase = PH_IDLE;
        line_n = 2'b10;
        nxt();
        line_n = 2'b11;
        mid();
        check("R9 line 0 granted", 32'(pull), 1);
        nxt();
        line_n = 2'b01;
        mid();
        check("R9 no pull while floated", 32'(pull), 0);
        nxt();
        line_n = 2'b11;
        nxt();
        give_back(0, 1'b0);
        mid();
        check("R9 kept request served after gap", 32'(pull), 2);
        nxt();
        nxt();
        give_back(1, 1'b0);
        nxt();
    endtask

    task automatic t_idle_then_mem();
        phase = PH_IDLE;
        line_n = 2'b10;
        nxt();
        line_n = 2'b11;
        phase = PH_T1;
        mid();
        check("R12 no pulse in T1", 32'(pull), 0);
        nxt();
        phase = PH_T2;
        nxt();
        phase = PH_T3;
        nxt();
        phase = PH_T4;
        mid();
        check("R12 pulse in T4", 32'(pull), 1);
        nxt();
        phase = PH_IDLE;
        nxt();
        give_back(0, 1'b0);
    endtask

    task automatic t_lock();
        phase = PH_T1;
        locked = 1'b1;
        mid();
        check("R10 lock low", 32'(lock_n), 0);
        nxt();
        locked = 1'b0;
        mid();
        check("R10 lock high after", 32'(lock_n), 1);
        nxt();
    endtask

    task automatic t_inta();
        inta = 1'b1;
        inta_first = 1'b1;
        phase = PH_T1;
        mid();
        check("R11 high in first T1", 32'(lock_n), 1);
        nxt();
        phase = PH_T2;
        mid();
        check("R11 low in first T2", 32'(lock_n), 0);
        nxt();
        phase = PH_T3;
        nxt();
        phase = PH_T4;
        nxt();
        inta = 1'b0;
        inta_first = 1'b0;
        phase = PH_IDLE;
        mid();
        check("R11 held between cycles", 32'(lock_n), 0);
        nxt();
        inta = 1'b1;
        phase = PH_T1;
        mid();
        check("R11 held in second T1", 32'(lock_n), 0);
        nxt();
        phase = PH_T2;
        mid();
        check("R11 high in second T2", 32'(lock_n), 1);
        nxt();
        inta = 1'b0;
        phase = PH_IDLE;
        mid();
        check("R11 stays high", 32'(lock_n), 1);
        nxt();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        phase = PH_IDLE;
        split_low = 1'b0;
        inta = 1'b0;
        inta_first = 1'b0;
        locked = 1'b0;
        pending = 1'b0;
        line_n = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_idle_grant();
        t_mem_t2();
        t_late();
        for (int k = 0; k < 3; k++) t_block(k);
        t_prio();
        t_float_req();
        t_idle_then_mem();
        t_lock();
        t_inta();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule